// File: doc/BRIEF.md
# Match/Capture Timer Channel

One channel of a multi-channel timing engine. It watches one of two shared 16-bit free-running time bases. A compare path raises a match event when the chosen time base reaches a programmed value, and it drives an output pin action in the same edge. A separate capture path records the time base on a chosen input-pin edge. Both events land in a small per-channel event register, so simultaneous events are all kept. Any latched event asserts a service request toward a central scheduler.

A link request from a neighbouring channel also latches a flag and raises the same request. The scheduler answers with a one-cycle acknowledge that clears every pending flag. Every instance of the channel is identical. Its behaviour is set only by its configuration word and its match value, so any channel can be set up for any timing job.

Top module: `mc_timer_chan`

## Requirements
- R1: After reset, match_flag_o, cap_flag_o, link_flag_o, srq_o and pin_o are 0, and cap_val_o is 16'h0000.
- R2: The configuration bit cfg_tb_sel_i selects the time base that both the match and capture paths use: 0 selects tb_a_i and 1 selects tb_b_i. The unselected base has no effect.
- R3: With match enabled, a match fires on a clock edge where the selected time base equals the match register and did not equal it at the previous edge. match_flag_o is 1 after that edge. A time base held at the match value fires only once.
- R4: With cfg_match_en_i stored as 0, equality sets no flag and leaves pin_o unchanged.
- R5: The pin action code cfg_pin_act_i is applied to pin_o on the same edge that sets match_flag_o. The codes are 0 hold, 1 set, 2 clear and 3 toggle.
- R6: The capture mode code cfg_cap_mode_i selects the edges that capture: 0 none, 1 rising, 2 falling, 3 either. An edge is pin_i compared with its value at the previous clock edge. On a selected edge, cap_val_o loads the selected time-base value of that cycle and cap_flag_o sets.
- R7: A match and a capture in the same cycle are both latched.
- R8: srq_o is 1 exactly while at least one of the match, capture or link flags is latched.
- R9: A one-cycle ack_i clears all latched flags, and flags hold until then. An event or link arriving in the acknowledge cycle stays latched.
- R10: A link_i pulse sets link_flag_o. Further link pulses while it is pending merge into it, so one acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Channel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tb_a_i | input | 16 | Shared time base A |
| tb_b_i | input | 16 | Shared time base B |
| cfg_wr_i | input | 1 | Stores the configuration fields below |
| cfg_tb_sel_i | input | 1 | Time-base select (0 A, 1 B) |
| cfg_match_en_i | input | 1 | Match enable |
| cfg_pin_act_i | input | 2 | Pin action on match |
| cfg_cap_mode_i | input | 2 | Capture edge mode |
| match_wr_i | input | 1 | Stores match_val_i |
| match_val_i | input | 16 | New match value |
| pin_i | input | 1 | Capture pin |
| link_i | input | 1 | Link request from another channel |
| ack_i | input | 1 | Scheduler acknowledge |
| pin_o | output | 1 | Output pin |
| cap_val_o | output | 16 | Captured time-base value |
| match_flag_o | output | 1 | Latched match event |
| cap_flag_o | output | 1 | Latched capture event |
| link_flag_o | output | 1 | Latched link request |
| srq_o | output | 1 | Service request |

## Verification
Configuration and match writes take effect one edge after their strobe. Every event, whether match, capture, link or acknowledge, shows on the flags, pin_o, cap_val_o and srq_o right after the clock edge that sees it. Nothing is due later than that. The bench drives inputs just after a falling edge, lets exactly one rising edge pass, and samples at the following falling edge. Each result is therefore read in the first cycle it is due, and before the next stimulus could disturb it.

// File: rtl/mc_chan_pkg.sv
package mc_chan_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } pin_act_e;

  typedef enum logic [1:0] {
    CAP_OFF  = 2'd0,
    CAP_RISE = 2'd1,
    CAP_FALL = 2'd2,
    CAP_ANY  = 2'd3
  } cap_mode_e;

  typedef struct packed {
    logic      tb_sel;
    logic      match_en;
    pin_act_e  act;
    cap_mode_e cap_mode;
  } chan_cfg_t;

  localparam int unsigned NUM_EVT   = 3;
  localparam int unsigned EVT_MATCH = 0;
  localparam int unsigned EVT_CAP   = 1;
  localparam int unsigned EVT_LINK  = 2;
endpackage

// File: rtl/mc_tb_mux.sv
module mc_tb_mux #(
  parameter int unsigned TB_W   = 16,
  parameter int unsigned NUM_TB = 2,
  localparam int unsigned SEL_W = (NUM_TB > 1) ? $clog2(NUM_TB) : 1
) (
  input  logic [NUM_TB-1:0][TB_W-1:0] tb_i,
  input  logic [SEL_W-1:0]            sel_i,
  output logic [TB_W-1:0]             tb_o
);
  always_comb begin
    tb_o = tb_i[0];
    for (int k = 1; k < NUM_TB; k++) begin
      if (sel_i == SEL_W'(k)) tb_o = tb_i[k];
    end
  end
endmodule

// File: rtl/mc_match_unit.sv
module mc_match_unit
  import mc_chan_pkg::*;
#(
  parameter int unsigned TB_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TB_W-1:0] tb_i,
  input  logic [TB_W-1:0] cmp_i,
  input  logic            en_i,
  input  pin_act_e        act_i,
  output logic            hit_o,
  output logic            pin_o
);
  logic eq, eq_q, pin_q;

  assign eq    = (tb_i == cmp_i);
  // one hit per equality window
  assign hit_o = en_i & eq & ~eq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else if (hit_o) begin
      unique case (act_i)
        ACT_SET:  pin_q <= 1'b1;
        ACT_CLR:  pin_q <= 1'b0;
        ACT_TGL:  pin_q <= ~pin_q;
        default:  pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/mc_capture_unit.sv
module mc_capture_unit
  import mc_chan_pkg::*;
#(
  parameter int unsigned TB_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TB_W-1:0] tb_i,
  input  logic            pin_i,
  input  cap_mode_e       mode_i,
  output logic            hit_o,
  output logic [TB_W-1:0] cap_o
);
  logic pin_q, rise, fall;
  logic [TB_W-1:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_i;
  end

  assign rise = pin_i & ~pin_q;
  assign fall = ~pin_i & pin_q;

  always_comb begin
    unique case (mode_i)
      CAP_RISE: hit_o = rise;
      CAP_FALL: hit_o = fall;
      CAP_ANY:  hit_o = rise | fall;
      default:  hit_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_q <= '0;
    else if (hit_o) cap_q <= tb_i;
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/mc_event_latch.sv
module mc_event_latch #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         ack_i,
  output logic [N-1:0] flag_o,
  output logic         srq_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    // set wins over ack; repeated sets merge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= set_i[g] | (flag_q & ~ack_i);
    end
    assign flag_o[g] = flag_q;
  end

  assign srq_o = |flag_o;
endmodule

// File: rtl/mc_timer_chan.sv
module mc_timer_chan
  import mc_chan_pkg::*;
#(
  parameter int unsigned TB_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TB_W-1:0] tb_a_i,
  input  logic [TB_W-1:0] tb_b_i,
  input  logic            cfg_wr_i,
  input  logic            cfg_tb_sel_i,
  input  logic            cfg_match_en_i,
  input  logic [1:0]      cfg_pin_act_i,
  input  logic [1:0]      cfg_cap_mode_i,
  input  logic            match_wr_i,
  input  logic [TB_W-1:0] match_val_i,
  input  logic            pin_i,
  input  logic            link_i,
  input  logic            ack_i,
  output logic            pin_o,
  output logic [TB_W-1:0] cap_val_o,
  output logic            match_flag_o,
  output logic            cap_flag_o,
  output logic            link_flag_o,
  output logic            srq_o
);
  chan_cfg_t          cfg_q;
  logic [TB_W-1:0]    match_q;
  logic [TB_W-1:0]    tb_sel_val;
  logic               match_hit, cap_hit;
  logic [NUM_EVT-1:0] evt_set, evt_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{tb_sel: 1'b0, match_en: 1'b0, act: ACT_HOLD, cap_mode: CAP_OFF};
    end else if (cfg_wr_i) begin
      cfg_q <= '{tb_sel:   cfg_tb_sel_i,
                 match_en: cfg_match_en_i,
                 act:      pin_act_e'(cfg_pin_act_i),
                 cap_mode: cap_mode_e'(cfg_cap_mode_i)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         match_q <= '0;
    else if (match_wr_i) match_q <= match_val_i;
  end

  mc_tb_mux #(.TB_W(TB_W), .NUM_TB(2)) u_tb_mux (
    .tb_i  ({tb_b_i, tb_a_i}),
    .sel_i (cfg_q.tb_sel),
    .tb_o  (tb_sel_val)
  );

  mc_match_unit #(.TB_W(TB_W)) u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tb_i   (tb_sel_val),
    .cmp_i  (match_q),
    .en_i   (cfg_q.match_en),
    .act_i  (cfg_q.act),
    .hit_o  (match_hit),
    .pin_o  (pin_o)
  );

  mc_capture_unit #(.TB_W(TB_W)) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tb_i   (tb_sel_val),
    .pin_i  (pin_i),
    .mode_i (cfg_q.cap_mode),
    .hit_o  (cap_hit),
    .cap_o  (cap_val_o)
  );

  always_comb begin
    evt_set            = '0;
    evt_set[EVT_MATCH] = match_hit;
    evt_set[EVT_CAP]   = cap_hit;
    evt_set[EVT_LINK]  = link_i;
  end

  mc_event_latch #(.N(NUM_EVT)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set),
    .ack_i  (ack_i),
    .flag_o (evt_flag),
    .srq_o  (srq_o)
  );

  assign match_flag_o = evt_flag[EVT_MATCH];
  assign cap_flag_o   = evt_flag[EVT_CAP];
  assign link_flag_o  = evt_flag[EVT_LINK];
endmodule

// File: rtl/mc_timer_chan_chk.sv
module mc_timer_chan_chk #(
  parameter int unsigned TB_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            match_hit,
  input logic            cap_hit,
  input logic            link_i,
  input logic            ack_i,
  input logic            men,
  input logic [1:0]      act,
  input logic [TB_W-1:0] tb_sel_val,
  input logic            pin_o,
  input logic [TB_W-1:0] cap_val_o,
  input logic            match_flag_o,
  input logic            cap_flag_o,
  input logic            link_flag_o,
  input logic            srq_o
);
  // R3
  match_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_hit |=> match_flag_o);

  // R4
  pin_still_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !men |=> pin_o == $past(pin_o));

  // R5
  pin_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_hit && act == 2'd3) |=> pin_o != $past(pin_o));

  // R6
  cap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hit |=> (cap_flag_o && cap_val_o == $past(tb_sel_val)));

  // R7
  both_events_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_hit && cap_hit) |=> (match_flag_o && cap_flag_o));

  // R9
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_flag_o && !ack_i) |=> match_flag_o);

  // R9
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !match_hit && !cap_hit && !link_i) |=> !srq_o);

  // R10
  link_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_i |=> (link_flag_o && srq_o));
endmodule

bind mc_timer_chan mc_timer_chan_chk #(.TB_W(TB_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .match_hit    (match_hit),
  .cap_hit      (cap_hit),
  .link_i       (link_i),
  .ack_i        (ack_i),
  .men          (cfg_q.match_en),
  .act          (cfg_q.act),
  .tb_sel_val   (tb_sel_val),
  .pin_o        (pin_o),
  .cap_val_o    (cap_val_o),
  .match_flag_o (match_flag_o),
  .cap_flag_o   (cap_flag_o),
  .link_flag_o  (link_flag_o),
  .srq_o        (srq_o)
);

// File: tb/mc_timer_chan_bench.sv
module mc_timer_chan_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] tb_a_i = '0, tb_b_i = '0, match_val_i = '0;
  logic        cfg_wr_i = 0, cfg_tb_sel_i = 0, cfg_match_en_i = 0;
  logic [1:0]  cfg_pin_act_i = '0, cfg_cap_mode_i = '0;
  logic        match_wr_i = 0, pin_i = 0, link_i = 0, ack_i = 0;
  logic        pin_o, match_flag_o, cap_flag_o, link_flag_o, srq_o;
  logic [15:0] cap_val_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic pin_m = 1'b0;

  always #4 clk_i = ~clk_i;

  mc_timer_chan u_mc_timer_chan (.*);

  // sel, act, match, tb_a, tb_b, fires
  localparam logic [51:0] VEC [8] = '{
    {1'b0, 2'd1, 16'h1234, 16'h1234, 16'h0000, 1'b1},
    {1'b0, 2'd2, 16'h00FF, 16'h00FF, 16'h00FF, 1'b1},
    {1'b1, 2'd3, 16'hABCD, 16'hABCD, 16'h0000, 1'b0},
    {1'b1, 2'd3, 16'hABCD, 16'h0000, 16'hABCD, 1'b1},
    {1'b0, 2'd0, 16'hFFFF, 16'hFFFF, 16'h0001, 1'b1},
    {1'b1, 2'd2, 16'h0000, 16'h0000, 16'h0000, 1'b1},
    {1'b0, 2'd1, 16'h8000, 16'h7FFF, 16'h8000, 1'b0},
    {1'b0, 2'd3, 16'h0001, 16'h0001, 16'h0000, 1'b1}
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic write_cfg(logic sel, logic men, logic [1:0] act, logic [1:0] mode);
    cfg_tb_sel_i = sel; cfg_match_en_i = men; cfg_pin_act_i = act; cfg_cap_mode_i = mode;
    cfg_wr_i = 1; tick(); cfg_wr_i = 0;
  endtask

  task automatic set_match(logic [15:0] v);
    match_val_i = v; match_wr_i = 1; tick(); match_wr_i = 0;
  endtask

  task automatic do_ack();
    ack_i = 1; tick(); ack_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_ni = 1; tick();
    // R1 reset state
    chk("R1", "match_flag", match_flag_o, 0);
    chk("R1", "cap_flag", cap_flag_o, 0);
    chk("R1", "link_flag", link_flag_o, 0);
    chk("R1", "srq", srq_o, 0);
    chk("R1", "pin", pin_o, 0);
    chk("R1", "cap_val", cap_val_o, 0);

    // R2 R3 R5 R8 table walk
    for (int i = 0; i < 8; i++) begin
      logic        sel, fire;
      logic [1:0]  act;
      logic [15:0] mv, ta, tbv;
      {sel, act, mv, ta, tbv, fire} = VEC[i];
      tb_a_i = ~mv; tb_b_i = ~mv;
      set_match(mv);
      write_cfg(sel, 1'b1, act, 2'd0);
      do_ack();
      tb_a_i = ta; tb_b_i = tbv;
      tick();
      if (fire) begin
        case (act)
          2'd1: pin_m = 1'b1;
          2'd2: pin_m = 1'b0;
          2'd3: pin_m = ~pin_m;
          default: ;
        endcase
      end
      chk("R3", $sformatf("vec%0d match_flag", i), match_flag_o, fire);
      chk("R5", $sformatf("vec%0d pin", i), pin_o, pin_m);
      chk("R8", $sformatf("vec%0d srq", i), srq_o, fire);
    end

    // R9 flags hold without ack; R3 no refire while held equal
    tick();
    chk("R9", "match flag held", match_flag_o, 1);
    do_ack(); tick(); tick();
    chk("R3", "held equality no refire", match_flag_o, 0);
    tb_a_i = 16'h0002; tick();
    tb_a_i = 16'h0001; tick();
    pin_m = ~pin_m;
    chk("R3", "refire after leaving", match_flag_o, 1);
    chk("R5", "second toggle", pin_o, pin_m);

    // R4 match disabled
    do_ack();
    write_cfg(1'b0, 1'b0, 2'd3, 2'd0);
    tb_a_i = 16'h0005; tick();
    tb_a_i = 16'h0001; tick();
    chk("R4", "disabled flag", match_flag_o, 0);
    chk("R4", "disabled pin", pin_o, pin_m);

    // R6 capture modes; R2 capture base select
    write_cfg(1'b0, 1'b0, 2'd0, 2'd1);
    tb_a_i = 16'h0100; tb_b_i = 16'h0F00; pin_i = 1; tick();
    chk("R6", "rise flag", cap_flag_o, 1);
    chk("R6", "rise value", cap_val_o, 16'h0100);
    do_ack();
    tb_a_i = 16'h0111; pin_i = 0; tick();
    chk("R6", "fall ignored in rise mode", cap_flag_o, 0);
    chk("R6", "value kept", cap_val_o, 16'h0100);
    write_cfg(1'b0, 1'b0, 2'd0, 2'd2);
    pin_i = 1; tick();
    chk("R6", "rise ignored in fall mode", cap_flag_o, 0);
    tb_a_i = 16'h0222; pin_i = 0; tick();
    chk("R6", "fall value", cap_val_o, 16'h0222);
    do_ack();
    write_cfg(1'b1, 1'b0, 2'd0, 2'd3);
    tb_b_i = 16'h0333; pin_i = 1; tick();
    chk("R2", "capture from base B", cap_val_o, 16'h0333);
    do_ack();
    write_cfg(1'b1, 1'b0, 2'd0, 2'd0);
    tb_b_i = 16'h0444; pin_i = 0; tick();
    chk("R6", "mode off no flag", cap_flag_o, 0);
    chk("R6", "mode off value", cap_val_o, 16'h0333);

    // R7 simultaneous match and capture
    write_cfg(1'b0, 1'b1, 2'd1, 2'd1);
    set_match(16'h0500);
    tb_a_i = 16'h0400; tick();
    do_ack();
    tb_a_i = 16'h0500; pin_i = 1; tick();
    chk("R7", "match flag", match_flag_o, 1);
    chk("R7", "cap flag", cap_flag_o, 1);
    chk("R7", "cap value", cap_val_o, 16'h0500);

    // R9 link in ack cycle kept
    ack_i = 1; link_i = 1; tick(); ack_i = 0; link_i = 0;
    chk("R9", "link kept", link_flag_o, 1);
    chk("R9", "match cleared", match_flag_o, 0);
    chk("R9", "cap cleared", cap_flag_o, 0);
    chk("R8", "srq from link", srq_o, 1);
    do_ack();
    chk("R9", "all cleared", srq_o, 0);

    // R10 merged links
    link_i = 1; tick(); tick(); link_i = 0; tick();
    chk("R10", "link pending", link_flag_o, 1);
    do_ack();
    chk("R10", "one ack clears merged", link_flag_o, 0);
    chk("R10", "srq low", srq_o, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule